// File: doc/BRIEF.md
# Dynamic-Priority Bus Arbiter

This block decides which of several masters on a shared on-chip bus may drive it next. Each master raises a request line and, alongside it, a two-bit urgency level that it may change from one request to the next. The arbiter looks only at the masters that are requesting, finds the most urgent level among them, and breaks ties by position, so that the lower-numbered master wins. The result is a one-hot grant vector with one line per master.

A decision always takes the same three cycles: snapshot, resolve, issue. A master keeps the bus for as long as it holds its request high. It gives the bus up by dropping that request. While one master owns the bus, the arbiter already decides among the other requesters. The pending winner then takes over on the same clock edge on which the owner lets go.

Top module: `dyn_prio_arbiter`

## Requirements
- R1: The number of masters is the parameter `NUM_MASTERS`, legal from 1 to 16. Every master, including the highest index `NUM_MASTERS-1`, can be granted.
- R2: Master i supplies its level on `prio_lvl[2*i+1:2*i]`. Value 3 is the most urgent and 0 the least. The granted master belongs to the highest level present among the snapshotted requesters, even when a lower-index master requests at a lower level.
- R3: A master whose `req` is low never receives a grant, and its `prio_lvl` field has no effect on the decision. A grant bit is only ever high in a cycle that follows a cycle in which that master's `req` was high.
- R4: Among snapshotted requesters that share the top level, the one with the lowest index wins.
- R5: The bus may be idle, with no grant active, when `req` is sampled on an edge. In that case the grant appears on the third edge, counting the sampling edge as the first, and is visible in the cycle after it.
- R6: A granted master keeps its grant for as long as its `req` stays high. Dropping `req` clears the grant on the next edge.
- R7: The current owner takes no part in arbitration. A decided winner waits while the owner holds the bus, and receives the grant on the very edge at which the owner's release is seen, with no idle cycle between the two owners.
- R8: Requests and levels are captured on the sampling edge. Changes made to them after that edge do not alter the decision in progress.
- R9: A winner whose `req` is low when the grant would be issued gets no grant, and the grant stays all zero.
- R10: At most one grant bit is high at any time, and the grant is all zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_MASTERS | Request line per master; held high to keep the bus |
| prio_lvl | input | 2*NUM_MASTERS | Two-bit urgency level per master, master i in bits 2i+1:2i |
| grant | output | NUM_MASTERS | One-hot grant, one line per master |

## Verification
The bench sets a high-level requester against a lower-index one at a lower level. A design that let index outrank level would grant the wrong master. It also creates a tie at the top level, where a design that picked by highest index would fail. The bench changes a level and adds a request just after the sampling edge. A design without a snapshot would then grant the late arrival. Hand-over is checked cycle by cycle, so a dead cycle between two owners, or a grant taken from a master that still holds `req`, shows up as a miscompare. A winner that withdraws before the issue cycle must not be granted. A design that issued from the stale snapshot alone would hand the bus to a master that no longer asks for it.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

   localparam int PRIO_W      = 2;
   localparam int LEVELS      = 1 << PRIO_W;
   localparam int MAX_MASTERS = 16;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_RESOLVE = 2'd1,
      ST_ISSUE   = 2'd2
   } arb_state_e;

endpackage

// File: rtl/dpa_snapshot.sv
module dpa_snapshot #(
   parameter int N  = 8,
   parameter int PW = dpa_pkg::PRIO_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [N-1:0]    req_i,
   input  logic [N*PW-1:0] prio_i,
   output logic [N-1:0]    req_s,
   output logic [N*PW-1:0] prio_s
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_s  <= '0;
         prio_s <= '0;
      end else if (load) begin
         req_s  <= req_i;
         prio_s <= prio_i;
      end
   end

endmodule

// File: rtl/dpa_resolver.sv
module dpa_resolver #(
   parameter int N      = 8,
   parameter int PW     = dpa_pkg::PRIO_W,
   parameter int LEVELS = dpa_pkg::LEVELS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            issue_phase,
   input  logic [N-1:0]    req_s,
   input  logic [N*PW-1:0] prio_s,
   output logic [N-1:0]    win_oh
);

   logic [LEVELS-1:0][N-1:0] at_lvl;
   logic [N-1:0]             top_cand;
   logic [N-1:0]             win_next;

   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      for (genvar m = 0; m < N; m++) begin : g_m
         assign at_lvl[l][m] = req_s[m] && (prio_s[m*PW +: PW] == PW'(l));
      end
   end

   // highest populated level overrides lower ones
   always_comb begin
      top_cand = '0;
      for (int l = 0; l < LEVELS; l++) begin
         if (|at_lvl[l]) top_cand = at_lvl[l];
      end
   end

   // lowest index inside the top level
   assign win_next = top_cand & (~top_cand + N'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  win_oh <= '0;
      else if (en) win_oh <= win_next;
   end

   assert_winner_in_snapshot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      issue_phase |-> ((win_oh & ~req_s) == '0));

   assert_winner_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_phase && (req_s != '0)) |-> $onehot(win_oh));

endmodule

// File: rtl/dpa_grant_ctrl.sv
module dpa_grant_ctrl #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   input  logic         issue,
   input  logic [N-1:0] win_oh,
   output logic         bus_free,
   output logic [N-1:0] grant_o
);

   logic [N-1:0] grant_q;

   // free when nobody owns the bus or the owner has dropped its request
   assign bus_free = ~|(grant_q & req_i);
   assign grant_o  = grant_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        grant_q <= '0;
      else if (issue)    grant_q <= win_oh & req_i;
      else if (bus_free) grant_q <= '0;
   end

   always @(posedge clk) begin
      if (!rst_n) assert_reset_clear_R10: assert (grant_q == '0);
   end

   assert_onehot_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_q));

   assert_grant_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant_q & ~$past(req_i)) == '0));

   assert_hold_while_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(grant_q & req_i)) |=> (grant_q == $past(grant_q)));

   assert_no_steal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant_q != '0) && ($past(grant_q) != '0) && (grant_q != $past(grant_q)))
      |-> (($past(grant_q) & $past(req_i)) == '0));

endmodule

// File: rtl/dyn_prio_arbiter.sv
module dyn_prio_arbiter #(
   parameter int NUM_MASTERS = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [NUM_MASTERS-1:0]                req,
   input  logic [NUM_MASTERS*dpa_pkg::PRIO_W-1:0] prio_lvl,
   output logic [NUM_MASTERS-1:0]                grant
);

   import dpa_pkg::*;

   localparam int N  = NUM_MASTERS;
   localparam int PW = PRIO_W;

   if (NUM_MASTERS < 1 || NUM_MASTERS > MAX_MASTERS) begin : g_bad_count_R1
      $error("NUM_MASTERS must lie between 1 and 16");
   end

   arb_state_e    st_q;
   logic [N-1:0]  contenders;
   logic          capture;
   logic          resolve_en;
   logic          issue_phase;
   logic          issue;
   logic          bus_free;
   logic [N-1:0]  req_s;
   logic [N*PW-1:0] prio_s;
   logic [N-1:0]  win_oh;

   // the owner does not compete against itself
   assign contenders  = req & ~grant;
   assign capture     = (st_q == ST_IDLE) && (contenders != '0);
   assign resolve_en  = (st_q == ST_RESOLVE);
   assign issue_phase = (st_q == ST_ISSUE);
   assign issue       = issue_phase && bus_free;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else begin
         unique case (st_q)
            ST_IDLE:    if (capture) st_q <= ST_RESOLVE;
            ST_RESOLVE: st_q <= ST_ISSUE;
            ST_ISSUE:   if (bus_free) st_q <= ST_IDLE;
            default:    st_q <= ST_IDLE;
         endcase
      end
   end

   dpa_snapshot #(.N(N), .PW(PW)) u_snap (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (capture),
      .req_i  (contenders),
      .prio_i (prio_lvl),
      .req_s  (req_s),
      .prio_s (prio_s)
   );

   dpa_resolver #(.N(N), .PW(PW)) u_res (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (resolve_en),
      .issue_phase (issue_phase),
      .req_s       (req_s),
      .prio_s      (prio_s),
      .win_oh      (win_oh)
   );

   dpa_grant_ctrl #(.N(N)) u_gnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req),
      .issue    (issue),
      .win_oh   (win_oh),
      .bus_free (bus_free),
      .grant_o  (grant)
   );

   assert_issue_after_resolve_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q == ST_ISSUE) |-> $past(st_q == ST_RESOLVE));

endmodule

// File: tb/tb_dyn_prio_arbiter.sv
module tb_dyn_prio_arbiter;

   localparam int NM = 8;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [NM-1:0]   req;
   logic [2*NM-1:0] prio_lvl;
   logic [NM-1:0]   grant;

   always #2.5 clk = ~clk;

   dyn_prio_arbiter #(.NUM_MASTERS(NM)) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .prio_lvl (prio_lvl),
      .grant    (grant)
   );

   typedef struct {
      int            cyc;
      logic [NM-1:0] g;
      string         tag;
   } exp_t;

   exp_t sb[$];
   int   cyc = 0;
   int   applied = 0;
   int   fails = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare scoreboard items due this cycle
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
         exp_t e;
         e = sb.pop_front();
         applied++;
         if (e.cyc != cyc || grant !== e.g) begin
            fails++;
            $display("FAIL %s: grant=%b expected=%b (cycle %0d, due %0d)",
                     e.tag, grant, e.g, cyc, e.cyc);
         end
      end
   end

   task automatic expect_grant(int dly, logic [NM-1:0] v, string tag);
      exp_t e;
      e.cyc = cyc + dly;
      e.g   = v;
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_m(int i, bit r, int p);
      req[i]          = r;
      prio_lvl[2*i+:2] = p[1:0];
   endtask

   function automatic logic [NM-1:0] m(int i);
      return NM'(1) << i;
   endfunction

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R5: actual=run still busy expected=run finished");
      summary();
      $finish;
   end

   initial begin
      rst_n    = 1'b0;
      req      = '0;
      prio_lvl = '0;
      step(3);
      applied++;
      if (grant !== '0) begin
         fails++;
         $display("FAIL R10 reset: grant=%b expected=%b", grant, {NM{1'b0}});
      end
      rst_n = 1'b1;
      step(3);

      // R5 latency and R1 top index; R6 hold then release
      set_m(7, 1, 0);
      expect_grant(1, '0, "R5 not yet (1)");
      expect_grant(2, '0, "R5 not yet (2)");
      expect_grant(3, m(7), "R5 third edge / R1 top index");
      expect_grant(5, m(7), "R6 held while requesting");
      step(5);
      set_m(7, 0, 0);
      expect_grant(1, '0, "R6 release clears grant");
      step(6);

      // R2 highest level wins; R7 hand-over chain without dead cycle
      set_m(1, 1, 1); set_m(5, 1, 3); set_m(6, 1, 2);
      expect_grant(3, m(5), "R2 level 3 wins");
      expect_grant(7, m(5), "R7 owner keeps bus while pending waits");
      step(7);
      set_m(5, 0, 3);
      expect_grant(1, m(6), "R7 direct hand-over to pending winner");
      step(5);
      set_m(6, 0, 2);
      expect_grant(1, m(1), "R7 second hand-over");
      step(4);
      set_m(1, 0, 1);
      expect_grant(1, '0, "R6 last owner releases");
      step(6);

      // R4 tie at top level; R9 withdrawn pending winner
      set_m(2, 1, 2); set_m(4, 1, 2); set_m(7, 1, 1);
      expect_grant(3, m(2), "R4 lower index wins tie");
      step(4);
      set_m(2, 0, 2); set_m(4, 0, 2); set_m(7, 0, 1);
      expect_grant(1, '0, "R9 owner gone");
      expect_grant(2, '0, "R9 withdrawn winner not granted");
      expect_grant(3, '0, "R9 still idle");
      step(6);

      // R3 non-requesting high level ignored
      set_m(0, 0, 3); set_m(3, 0, 3); set_m(6, 1, 0);
      expect_grant(3, m(6), "R3 idle master's level ignored");
      step(4);
      set_m(6, 0, 0);
      expect_grant(1, '0, "R3 release");
      expect_grant(3, '0, "R3 no grant to non-requester");
      step(6);

      // R8 late changes do not affect the decision in progress
      set_m(4, 1, 1); set_m(2, 1, 0);
      step(1);
      set_m(2, 1, 3); set_m(1, 1, 3);
      expect_grant(2, m(4), "R8 snapshot decision");
      step(3);
      set_m(4, 0, 1);
      expect_grant(1, '0, "R8 owner released");
      expect_grant(2, m(1), "R4 tie among late arrivals");
      step(2);
      set_m(1, 0, 3); set_m(2, 0, 3);
      expect_grant(1, '0, "R6 release");
      expect_grant(3, '0, "R9 nothing pending");
      step(6);

      // R9 winner withdraws between snapshot and issue
      set_m(5, 1, 2);
      step(1);
      set_m(5, 0, 2);
      expect_grant(2, '0, "R9 no grant after withdrawal");
      expect_grant(3, '0, "R9 still none");
      step(6);

      // R2 level beats index; hand-over to lower level afterwards
      set_m(0, 1, 2); set_m(7, 1, 3);
      expect_grant(3, m(7), "R2 level over index");
      step(4);
      set_m(7, 0, 3);
      expect_grant(1, '0, "R7 owner released before issue");
      expect_grant(2, m(0), "R7 pending winner granted");
      step(2);
      set_m(0, 0, 2);
      expect_grant(1, '0, "R6 final release");
      step(6);

      while (sb.size() > 0) step(1);
      summary();
      $finish;
   end

endmodule